// File: doc/BRIEF.md
# Packet Generator Register Bank

This block is the software-facing configuration store of a packet generator. A simple 32-bit memory-interface bus writes and reads ten word registers selected by the six lowest address bits. The registers hold the run switch, the frame length, the channel-stepping settings, the channel bounds and the two MAC addresses. Each stored field is driven straight out to the generator core. A 64-bit frame count arrives from the generator and is read back as two 32-bit halves that are guaranteed to belong together.

Requests are accepted in the cycle they are presented. Read data comes back one cycle later, marked by a single-cycle data-valid pulse. Byte enables are accepted but have no effect, so every write replaces the whole register. The frame counter is read-only. A read of its low half freezes the matching high half, and a later read of the high offset returns that frozen value.

Top module: `gen_cfg_regs`

## Requirements
- R1: Reset leaves `run_en`=0, the length at 0, `ch_step`=0x01, `ch_flags`=0x00, `burst_len`=0, `ch_lo`=0x0000, `ch_hi`=0xFFFF, both MACs at 0 and the frozen counter high half at 0. Register reads return these values.
- R2: `bus_ardy` is high in every cycle after reset.
- R3: `bus_rvalid` is high in the cycle after each cycle in which `bus_rd` is high, and low otherwise. Back-to-back reads give back-to-back pulses.
- R4: Only `bus_addr[5:0]` selects a register. Any value in bits [31:6] reaches the same register.
- R5: A write to offset 0x00 sets `run_en` to bit 0 of the write data (1 starts, 0 stops). A read returns `run_en` in bit 0 and zeros above it.
- R6: Offset 0x08 packs the channel step in bits [7:0], the option flags in bits [15:8] and the burst length in bits [31:16].
- R7: Offset 0x0C packs `ch_lo` in bits [15:0] and `ch_hi` in bits [31:16].
- R8: Offsets 0x10 and 0x18 hold bits [31:0] of the destination MAC and the source MAC. Offsets 0x14 and 0x1C hold bits [47:32] of the same MACs in data bits [15:0]. Bits [31:16] of those two offsets are not stored and read as zero.
- R9: `bus_ben` has no effect. Every write updates all stored bits of the addressed register, including when `bus_ben` is 0.
- R10: Offsets that are not multiples of 4, and offsets 0x28 through 0x3F, read as zero. Writes to them change no register.
- R11: A read of offset 0x20 returns `frame_count[31:0]` as it is in the read cycle, and it freezes `frame_count[63:32]` at the same time. A read of offset 0x24 returns the last frozen value.
- R12: Offset 0x04 holds a LEN_W-bit frame length (16 by default) in bits [LEN_W-1:0]. It drives `frame_len`, and the bits above it read as zero.
- R13: Writes to offsets 0x20 and 0x24 change neither the counter readback nor the frozen high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Request address; only bits [5:0] are decoded |
| bus_wdata | input | 32 | Write data |
| bus_ben | input | 4 | Byte enables; no effect |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_ardy | output | 1 | Request accepted; held high |
| bus_rdata | output | 32 | Read data; zero when not valid |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| run_en | output | 1 | Generator run switch |
| frame_len | output | LEN_W | Frame length |
| ch_step | output | 8 | Channel step |
| ch_flags | output | 8 | Channel option flags |
| burst_len | output | 16 | Frames per channel burst |
| ch_lo | output | 16 | Lowest channel |
| ch_hi | output | 16 | Highest channel |
| dst_mac | output | 48 | Destination MAC |
| src_mac | output | 48 | Source MAC |
| frame_count | input | CNT_W | Live generated-frame count |

## Verification
The bench compares each readback with a model it keeps itself.
- **Decode error.** A fault in the decoder writes the wrong field or returns the wrong word. The bench sees this on the first readback of an affected offset, one cycle after the read strobe. It also sees it at once on the configuration output ports after the write.
- **Reset error.** A wrong reset value shows on the outputs in the first cycle after reset.
- **Freeze error.** A wrong frozen counter half stays hidden until the next read of the high offset. To expose it, the bench reads the high offset before any low read and again after the live count has moved.

// File: rtl/gen_cfg_pkg.sv
package gen_cfg_pkg;
  localparam int REG_COUNT = 10;
  localparam int OFF_W     = 6;

  typedef enum logic [3:0] {
    IDX_CTRL     = 4'd0,
    IDX_LEN      = 4'd1,
    IDX_CHSTEP   = 4'd2,
    IDX_CHRANGE  = 4'd3,
    IDX_DMAC_LO  = 4'd4,
    IDX_DMAC_HI  = 4'd5,
    IDX_SMAC_LO  = 4'd6,
    IDX_SMAC_HI  = 4'd7,
    IDX_CNT_LO   = 4'd8,
    IDX_CNT_HI   = 4'd9
  } reg_idx_e;

  localparam logic [7:0]  STEP_RST  = 8'h01;
  localparam logic [7:0]  FLAGS_RST = 8'h00;
  localparam logic [15:0] CHLO_RST  = 16'h0000;
  localparam logic [15:0] CHHI_RST  = 16'hFFFF;

  // Byte offset of a register index: word registers at multiples of 4
  function automatic logic [OFF_W-1:0] reg_offset(input int idx);
    return OFF_W'(idx * 4);
  endfunction

  // Channel-step word: burst length high, flags middle, step low
  function automatic logic [31:0] pack_step(input logic [7:0] step,
                                            input logic [7:0] flags,
                                            input logic [15:0] burst);
    return {burst, flags, step};
  endfunction

  // Two 16-bit halves, low half in bits [15:0]
  function automatic logic [31:0] pack_pair(input logic [15:0] lo,
                                            input logic [15:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/gen_cfg_decode.sv
module gen_cfg_decode
  import gen_cfg_pkg::*;
(
  input  logic [OFF_W-1:0]     off,
  output logic [REG_COUNT-1:0] sel,
  output logic                 hit
);
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_sel
    assign sel[g] = (off == reg_offset(g));
  end
  assign hit = |sel;
endmodule

// File: rtl/gen_cfg_store.sv
module gen_cfg_store
  import gen_cfg_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [REG_COUNT-1:0] sel,
  input  logic [31:0]          wdata,
  output logic                 run_en,
  output logic [LEN_W-1:0]     frame_len,
  output logic [7:0]           ch_step,
  output logic [7:0]           ch_flags,
  output logic [15:0]          burst_len,
  output logic [15:0]          ch_lo,
  output logic [15:0]          ch_hi,
  output logic [47:0]          dst_mac,
  output logic [47:0]          src_mac
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      frame_len <= '0;
      ch_step   <= STEP_RST;
      ch_flags  <= FLAGS_RST;
      burst_len <= '0;
      ch_lo     <= CHLO_RST;
      ch_hi     <= CHHI_RST;
      dst_mac   <= '0;
      src_mac   <= '0;
    end else if (wr) begin
      if (sel[IDX_CTRL])    run_en <= wdata[0];
      if (sel[IDX_LEN])     frame_len <= wdata[LEN_W-1:0];
      if (sel[IDX_CHSTEP]) begin
        ch_step   <= wdata[7:0];
        ch_flags  <= wdata[15:8];
        burst_len <= wdata[31:16];
      end
      if (sel[IDX_CHRANGE]) begin
        ch_lo <= wdata[15:0];
        ch_hi <= wdata[31:16];
      end
      if (sel[IDX_DMAC_LO]) dst_mac[31:0]  <= wdata;
      if (sel[IDX_DMAC_HI]) dst_mac[47:32] <= wdata[15:0];
      if (sel[IDX_SMAC_LO]) src_mac[31:0]  <= wdata;
      if (sel[IDX_SMAC_HI]) src_mac[47:32] <= wdata[15:0];
    end
  end
endmodule

// File: rtl/gen_cfg_rdmux.sv
module gen_cfg_rdmux
  import gen_cfg_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd,
  input  logic [REG_COUNT-1:0] sel,
  input  logic                 run_en,
  input  logic [LEN_W-1:0]     frame_len,
  input  logic [7:0]           ch_step,
  input  logic [7:0]           ch_flags,
  input  logic [15:0]          burst_len,
  input  logic [15:0]          ch_lo,
  input  logic [15:0]          ch_hi,
  input  logic [47:0]          dst_mac,
  input  logic [47:0]          src_mac,
  input  logic [CNT_W-1:0]     frame_count,
  output logic [31:0]          rdata,
  output logic                 rvalid,
  output logic                 snap_evt,
  output logic [CNT_W-33:0]    cnt_hold
);
  localparam int HI_W = CNT_W - 32;

  logic [31:0] word_of [REG_COUNT];
  logic [31:0] rd_word;

  assign word_of[IDX_CTRL]    = {31'b0, run_en};
  assign word_of[IDX_LEN]     = 32'(frame_len);
  assign word_of[IDX_CHSTEP]  = pack_step(ch_step, ch_flags, burst_len);
  assign word_of[IDX_CHRANGE] = pack_pair(ch_lo, ch_hi);
  assign word_of[IDX_DMAC_LO] = dst_mac[31:0];
  assign word_of[IDX_DMAC_HI] = pack_pair(dst_mac[47:32], 16'h0000);
  assign word_of[IDX_SMAC_LO] = src_mac[31:0];
  assign word_of[IDX_SMAC_HI] = pack_pair(src_mac[47:32], 16'h0000);
  assign word_of[IDX_CNT_LO]  = frame_count[31:0];
  assign word_of[IDX_CNT_HI]  = 32'(cnt_hold);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (sel[i]) rd_word = rd_word | word_of[i];
    end
  end

  assign snap_evt = rd && sel[IDX_CNT_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid   <= 1'b0;
      rdata    <= '0;
      cnt_hold <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rd_word : 32'h0;
      if (snap_evt) cnt_hold <= frame_count[CNT_W-1:32];
    end
  end

  if (HI_W < 1 || HI_W > 32) begin : g_bad_width
    initial $error("CNT_W must be in 33..64");
  end
endmodule

// File: rtl/gen_cfg_regs.sv
module gen_cfg_regs
  import gen_cfg_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_ben,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              bus_ardy,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              run_en,
  output logic [LEN_W-1:0]  frame_len,
  output logic [7:0]        ch_step,
  output logic [7:0]        ch_flags,
  output logic [15:0]       burst_len,
  output logic [15:0]       ch_lo,
  output logic [15:0]       ch_hi,
  output logic [47:0]       dst_mac,
  output logic [47:0]       src_mac,
  input  logic [CNT_W-1:0]  frame_count
);
  logic [OFF_W-1:0]     off;
  logic [REG_COUNT-1:0] sel;
  logic                 hit;
  logic                 snap_evt;
  logic [CNT_W-33:0]    cnt_hold;

  assign off      = bus_addr[OFF_W-1:0];
  assign bus_ardy = 1'b1;

  gen_cfg_decode u_dec (
    .off (off),
    .sel (sel),
    .hit (hit)
  );

  gen_cfg_store #(.LEN_W(LEN_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .sel       (sel),
    .wdata     (bus_wdata),
    .run_en    (run_en),
    .frame_len (frame_len),
    .ch_step   (ch_step),
    .ch_flags  (ch_flags),
    .burst_len (burst_len),
    .ch_lo     (ch_lo),
    .ch_hi     (ch_hi),
    .dst_mac   (dst_mac),
    .src_mac   (src_mac)
  );

  gen_cfg_rdmux #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd          (bus_rd),
    .sel         (sel),
    .run_en      (run_en),
    .frame_len   (frame_len),
    .ch_step     (ch_step),
    .ch_flags    (ch_flags),
    .burst_len   (burst_len),
    .ch_lo       (ch_lo),
    .ch_hi       (ch_hi),
    .dst_mac     (dst_mac),
    .src_mac     (src_mac),
    .frame_count (frame_count),
    .rdata       (bus_rdata),
    .rvalid      (bus_rvalid),
    .snap_evt    (snap_evt),
    .cnt_hold    (cnt_hold)
  );
endmodule

// File: rtl/gen_cfg_chk.sv
module gen_cfg_chk #(
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       bus_addr,
  input logic [3:0]        bus_ben,
  input logic              ctrl_bit,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_ardy,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              run_en,
  input logic [7:0]        ch_step,
  input logic [15:0]       ch_hi,
  input logic              hit,
  input logic              snap_evt,
  input logic [CNT_W-33:0] cnt_hold,
  input logic [CNT_W-33:0] cnt_hi_live
);
  // R2
  ardy_high_chk: assert property (@(posedge clk) disable iff (rst) bus_ardy);

  // R3
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R3
  rvalid_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));

  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ch_step == 8'h01 && ch_hi == 16'hFFFF && !run_en));

  // R5
  run_follows_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[5:0] == 6'h00) |=> (run_en == $past(ctrl_bit)));

  // R9
  ben_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_ben == 4'h0 && bus_addr[5:0] == 6'h00) |=> (run_en == $past(ctrl_bit)));

  // R4
  alias_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[31:6] != 26'h0 && bus_addr[5:0] == 6'h00) |=> (run_en == $past(ctrl_bit)));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> (bus_rdata == 32'h0));

  // R8
  mac_hi_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr[5:0] == 6'h14 || bus_addr[5:0] == 6'h1C)) |=> (bus_rdata[31:16] == 16'h0));

  // R11
  snapshot_chk: assert property (@(posedge clk) disable iff (rst)
    snap_evt |=> (cnt_hold == $past(cnt_hi_live)));
endmodule

bind gen_cfg_regs gen_cfg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_ben     (bus_ben),
  .ctrl_bit    (bus_wdata[0]),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_ardy    (bus_ardy),
  .bus_rdata   (bus_rdata),
  .bus_rvalid  (bus_rvalid),
  .run_en      (run_en),
  .ch_step     (ch_step),
  .ch_hi       (ch_hi),
  .hit         (hit),
  .snap_evt    (snap_evt),
  .cnt_hold    (cnt_hold),
  .cnt_hi_live (frame_count[CNT_W-1:32])
);

// File: tb/sim_gen_cfg_regs.sv
`timescale 1ns/1ps
module sim_gen_cfg_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_ben = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_ardy;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        run_en;
  logic [15:0] frame_len;
  logic [7:0]  ch_step, ch_flags;
  logic [15:0] burst_len, ch_lo, ch_hi;
  logic [47:0] dst_mac, src_mac;
  logic [63:0] frame_count = '0;

  int checks = 0;
  int failures = 0;

  logic [31:0] shadow [10];
  logic [31:0] hold_exp;

  always #2.5 clk = ~clk;

  gen_cfg_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ben(bus_ben), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ardy(bus_ardy),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .run_en(run_en),
    .frame_len(frame_len), .ch_step(ch_step), .ch_flags(ch_flags),
    .burst_len(burst_len), .ch_lo(ch_lo), .ch_hi(ch_hi), .dst_mac(dst_mac),
    .src_mac(src_mac), .frame_count(frame_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Mapped offsets: multiples of 4 below 0x28
  function automatic bit mapped(input logic [5:0] off);
    return (off[1:0] == 2'b00) && (off < 6'h28);
  endfunction

  function automatic logic [31:0] wmask(input int idx);
    case (idx)
      0: return 32'h0000_0001;
      1: return 32'h0000_FFFF;
      5, 7: return 32'h0000_FFFF;
      8, 9: return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] off);
    if (!mapped(off)) return "R10";
    case (off)
      6'h00: return "R5";
      6'h04: return "R12";
      6'h08: return "R6";
      6'h0C: return "R7";
      6'h20, 6'h24: return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic model_write(input logic [5:0] off, input logic [31:0] d);
    if (mapped(off)) begin
      int idx = int'(off >> 2);
      if (idx < 8) shadow[idx] = d & wmask(idx);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [5:0] off);
    if (!mapped(off)) return 32'h0;
    if (off == 6'h20) return frame_count[31:0];
    if (off == 6'h24) return hold_exp;
    return shadow[int'(off >> 2)];
  endfunction

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_ben = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a[5:0], d);
  endtask

  task automatic read_chk(input logic [31:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp = exp_read(a[5:0]);
    @(posedge clk); #1;
    chk("R3 rvalid", 64'(bus_rvalid), 64'd1);
    chk(req, 64'(bus_rdata), 64'(exp));
    if (a[5:0] == 6'h20) hold_exp = frame_count[63:32];
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ports_chk(input string req);
    chk({req, " run_en"}, 64'(run_en), 64'(shadow[0][0]));
    chk({req, " frame_len R12"}, 64'(frame_len), 64'(shadow[1][15:0]));
    chk({req, " ch_step R6"}, 64'(ch_step), 64'(shadow[2][7:0]));
    chk({req, " ch_flags R6"}, 64'(ch_flags), 64'(shadow[2][15:8]));
    chk({req, " burst_len R6"}, 64'(burst_len), 64'(shadow[2][31:16]));
    chk({req, " ch_lo R7"}, 64'(ch_lo), 64'(shadow[3][15:0]));
    chk({req, " ch_hi R7"}, 64'(ch_hi), 64'(shadow[3][31:16]));
    chk({req, " dst_mac R8"}, 64'(dst_mac), 64'({shadow[5][15:0], shadow[4]}));
    chk({req, " src_mac R8"}, 64'(src_mac), 64'({shadow[7][15:0], shadow[6]}));
    chk({req, " ardy R2"}, 64'(bus_ardy), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) shadow[i] = 32'h0;
    shadow[2] = 32'h0000_0001;
    shadow[3] = 32'hFFFF_0000;
    hold_exp = 32'h0;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: outputs right after reset
    ports_chk("R1");
    chk("R3 idle rvalid", 64'(bus_rvalid), 64'd0);
    for (int i = 0; i < 10; i++) read_chk(32'(i * 4), "R1 readback");

    // R11: high read before any low read gives reset hold, then snapshot
    frame_count = 64'h0123_4567_89AB_CDEF;
    read_chk(32'h24, "R11 hold before snapshot");
    read_chk(32'h20, "R11 low live");
    frame_count = 64'hFEDC_BA98_7654_3210;
    read_chk(32'h24, "R11 frozen high");
    read_chk(32'h20, "R11 low live again");
    read_chk(32'h24, "R11 new frozen high");

    // Sweep: aliased writes with varied byte enables, then read every offset
    for (int p = 0; p < 4; p++) begin
      frame_count = {32'h1000_0000 * 32'(p + 1) + 32'h55, 32'hA0A0_0000 + 32'(p)};
      for (int i = 0; i < 10; i++) begin
        logic [31:0] a, d;
        a = (32'(p * 37 + i + 1) << 6) | 32'(i * 4);   // R4: upper bits set
        d = 32'h9E37_79B9 * 32'(i + 1) ^ (32'h0101_0101 * 32'(p));
        bus_write(a, d, 4'(p * 5 + i));                // R9: varied enables
      end
      ports_chk("sweep");
      for (int o = 0; o < 64; o++) begin
        logic [31:0] a;
        a = (32'(p + 1) << (7 + p * 5)) | 32'(o);      // R4
        read_chk(a, tag_of(6'(o)));
      end
    end

    // R10: writes to unmapped offsets change nothing
    for (int o = 0; o < 64; o++) begin
      if (!mapped(6'(o))) bus_write(32'(o), 32'hFFFF_FFFF, 4'hF);
    end
    ports_chk("R10 unmapped writes");

    // R13: writes to counter offsets are ignored
    frame_count = 64'h2222_3333_4444_5555;
    read_chk(32'h20, "R11 snapshot before R13");
    bus_write(32'h24, 32'hDEAD_BEEF, 4'hF);
    bus_write(32'h20, 32'hCAFE_F00D, 4'hF);
    read_chk(32'h24, "R13 hold unchanged");
    read_chk(32'h20, "R13 low still live");

    // R5 / R9: control bit 0 only, enables ignored
    bus_write(32'h0, 32'h1, 4'hF);
    #1 chk("R5 start", 64'(run_en), 64'd1);
    bus_write(32'h0, 32'hFFFF_FFFE, 4'hF);
    #1 chk("R5 stop on bit0 clear", 64'(run_en), 64'd0);
    bus_write(32'h0, 32'h3, 4'h0);
    #1 chk("R9 zero enables still write", 64'(run_en), 64'd1);
    read_chk(32'h0, "R5 readback bit0");
    bus_write(32'h08, 32'hBEEF_0305, 4'h0);
    #1 chk("R9 full word with zero enables", 64'({burst_len, ch_flags, ch_step}), 64'h0000_BEEF_0305);

    // R3: back-to-back reads give back-to-back pulses
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 32'h08;
    @(posedge clk); #1;
    chk("R3 first pulse", 64'(bus_rvalid), 64'd1);
    chk("R6 b2b data", 64'(bus_rdata), 64'h0000_0000_BEEF_0305);
    @(negedge clk); bus_addr = 32'h0C;
    @(posedge clk); #1;
    chk("R3 second pulse", 64'(bus_rvalid), 64'd1);
    chk("R7 b2b data", 64'(bus_rdata), 64'(shadow[3]));
    @(negedge clk); bus_rd = 1'b0;
    @(posedge clk); #1;
    chk("R3 pulse ends", 64'(bus_rvalid), 64'd0);
    chk("R3 data cleared", 64'(bus_rdata), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule